// File: doc/BRIEF.md
# Scheduled Periodic Pin Output

This block drives a single output pin with a square wave of 50% duty cycle whose edges are placed on a free-running time counter, counted in ticks. Software loads an absolute start time and an edge-to-edge interval (half of the full period), then issues a command word. Once a start is accepted, the pin makes its first transition when the counter reaches the start time. After that, it makes one transition every interval. The full period is therefore twice the interval register; with an 8 ns tick the output frequency is 1 s / (2 × interval × 8 ns).

Each edge time is derived from the previous edge time plus the interval, not from the time at which the edge was seen, so the schedule does not wander. A stop command ends toggling and leaves the pin at whatever level it holds. A start is refused unless the programmed start time is strictly later than the counter value at the moment the command arrives. With the default 32-bit interval register and an 8 ns tick, periods beyond roughly 68.7 s cannot be expressed.

Top module: `sched_pin_out`

## Requirements
- R1: After reset the pin is low and the block is idle, so no transition occurs until a start is accepted.
- R2: A command word is acted on only when its bit 31 (valid) is 1. Bit 28 requests a start and bit 27 requests a stop. A word without the valid bit, or a valid word with neither of those bits set, has no effect.
- R3: A start request is refused, with no effect on the pin or the schedule, when the start-time register is not strictly greater than the counter value in the command cycle (equal is refused), or when the interval register is zero.
- R4: An accepted start drives the pin low. The pin stays low until the first clock edge at which the counter is at or beyond the start time, and the pin rises at that edge.
- R5: After the first edge, the pin toggles exactly when the counter reaches start + k × interval for k = 1, 2, …, giving a 50% duty square wave of period 2 × interval.
- R6: A valid command with both the start and the stop bit set is treated as a stop.
- R7: An accepted stop halts toggling and holds the pin at its current level. A stop while idle changes nothing.
- R8: Writes to the start-time or interval register while the output is running do not alter the waveform in progress. They are used only by the next accepted start.
- R9: An accepted start while already running abandons the old schedule: the pin goes low and follows the new start time and interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the time counter advances in this domain |
| rst_n | input | 1 | Synchronous reset, active low |
| now_ticks | input | TIME_W | Current value of the time counter in ticks |
| cmd_we | input | 1 | Command word strobe |
| cmd_word | input | 32 | Command word (bit 31 valid, bit 28 start, bit 27 stop) |
| start_we | input | 1 | Write strobe for the start-time register |
| start_val | input | TIME_W | New start time in ticks |
| half_we | input | 1 | Write strobe for the interval register |
| half_val | input | HALF_W | New edge-to-edge interval in ticks |
| pin_out | output | 1 | Scheduled square-wave output |

## Verification
The bench builds the block with a 16-bit time counter and a 4-bit interval register. With those widths it can sweep every non-zero interval from 1 to 15, each one through several full periods, in a few thousand cycles. The small counter also makes it cheap to place start times exactly at, before and one past the current count, which covers the boundaries of the start check. Every cycle's pin level is compared with an arithmetic model that computes the parity of the number of elapsed intervals since the start.

// File: rtl/spo_pkg.sv
// Shared definitions for the scheduled periodic pin output.
// Assumes a 32-bit command word whose flag positions are fixed by software.
package spo_pkg;

    localparam int CMD_W     = 32;
    localparam int VALID_BIT = 31;
    localparam int START_BIT = 28;
    localparam int STOP_BIT  = 27;

    typedef enum logic [1:0] {
        SPO_IDLE  = 2'd0,
        SPO_ARMED = 2'd1,
        SPO_RUN   = 2'd2
    } spo_state_e;

endpackage

// File: rtl/spo_cmd_decode.sv
// Command decoder: turns a strobed command word into one-cycle start and
// stop requests. Assumes the strobe is a single-cycle pulse per word.
// A word with both flags set yields only a stop.
module spo_cmd_decode
    import spo_pkg::*;
(
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             start_go,
    output logic             stop_go
);

    logic word_ok;

    // Qualify the word with its strobe and valid flag, then split the requests.
    always_comb begin
        word_ok  = cmd_we && cmd_word[VALID_BIT];
        stop_go  = word_ok && cmd_word[STOP_BIT];
        start_go = word_ok && cmd_word[START_BIT] && !cmd_word[STOP_BIT];
    end

endmodule

// File: rtl/spo_cfg_regs.sv
// Holding registers for the start time and the edge interval.
// Assumes writes may arrive at any time; consumers snapshot them on start.
module spo_cfg_regs #(
    parameter int TIME_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic [TIME_W-1:0] start_val,
    input  logic              half_we,
    input  logic [HALF_W-1:0] half_val,
    output logic [TIME_W-1:0] start_q,
    output logic [HALF_W-1:0] half_q
);

    // Capture the start time on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (start_we) start_q <= start_val;
    end

    // Capture the edge interval on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       half_q <= '0;
        else if (half_we) half_q <= half_val;
    end

endmodule

// File: rtl/spo_edge_sched.sv
// Edge scheduler: holds the next edge time, compares it with the counter
// and toggles the pin. Assumes the counter moves forward monotonically.
// Priority per cycle: stop, then accepted start, then a due edge.
module spo_edge_sched
    import spo_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_ticks,
    input  logic              start_go,
    input  logic              stop_go,
    input  logic [TIME_W-1:0] start_q,
    input  logic [HALF_W-1:0] half_q,
    output logic              pin_q,
    output spo_state_e        state_q
);

    localparam int PAD_W = TIME_W - HALF_W;

    logic [TIME_W-1:0] next_q;
    logic [HALF_W-1:0] half_snap;
    logic [TIME_W-1:0] step_ext;
    logic              launch_ok;
    logic              edge_due;

    // Decide whether a start is acceptable and whether an edge is due now.
    always_comb begin
        step_ext  = {{PAD_W{1'b0}}, half_snap};
        launch_ok = start_go && (start_q > now_ticks) && (half_q != '0);
        edge_due  = (state_q != SPO_IDLE) && (now_ticks >= next_q);
    end

    // Sequence the state, schedule and pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SPO_IDLE;
            pin_q     <= 1'b0;
            next_q    <= '0;
            half_snap <= '0;
        end else if (stop_go) begin
            state_q <= SPO_IDLE;
        end else if (launch_ok) begin
            state_q   <= SPO_ARMED;
            pin_q     <= 1'b0;
            next_q    <= start_q;
            half_snap <= half_q;
        end else if (edge_due) begin
            state_q <= SPO_RUN;
            pin_q   <= ~pin_q;
            next_q  <= next_q + step_ext;
        end
    end

    // R4: while waiting for the first edge the pin is low.
    a_r4_armed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPO_ARMED) |-> !pin_q);

    // R5: each taken edge moves the schedule forward by exactly one interval.
    a_r5_step_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_due && !stop_go && !start_go) |=>
            (next_q == $past(next_q) + $past(step_ext)));

    // R5: no transition while the counter is short of the next edge.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SPO_IDLE && now_ticks < next_q && !start_go) |=> $stable(pin_q));

    // R7: a stop idles the block and freezes the pin.
    a_r7_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stop_go |=> (state_q == SPO_IDLE) && $stable(pin_q));

    // R7: an idle block without an accepted start keeps its level.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPO_IDLE && !launch_ok) |=> $stable(pin_q) && state_q == SPO_IDLE);

    // R3: a start time not in the future leaves an idle block idle.
    a_r3_past_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPO_IDLE && start_go && !(start_q > now_ticks)) |=> (state_q == SPO_IDLE));

endmodule

// File: rtl/sched_pin_out.sv
// Scheduled periodic pin output: a 50% duty square wave whose edges are
// placed on an absolute tick counter. Assumes now_ticks is supplied by the
// time counter of the same clock domain and advances monotonically.
module sched_pin_out
    import spo_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_ticks,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              start_we,
    input  logic [TIME_W-1:0] start_val,
    input  logic              half_we,
    input  logic [HALF_W-1:0] half_val,
    output logic              pin_out
);

    logic              start_go;
    logic              stop_go;
    logic [TIME_W-1:0] start_q;
    logic [HALF_W-1:0] half_q;
    spo_state_e        state_q;

    spo_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_word (cmd_word),
        .start_go (start_go),
        .stop_go  (stop_go)
    );

    spo_cfg_regs #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_we  (start_we),
        .start_val (start_val),
        .half_we   (half_we),
        .half_val  (half_val),
        .start_q   (start_q),
        .half_q    (half_q)
    );

    spo_edge_sched #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .now_ticks (now_ticks),
        .start_go  (start_go),
        .stop_go   (stop_go),
        .start_q   (start_q),
        .half_q    (half_q),
        .pin_q     (pin_out),
        .state_q   (state_q)
    );

    // R6: a valid word carrying both flags stops the output and keeps the pin.
    a_r6_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[VALID_BIT] && cmd_word[STOP_BIT] && cmd_word[START_BIT])
            |=> (state_q == SPO_IDLE) && $stable(pin_out));

    // R2: a word without the valid flag never wakes an idle block.
    a_r2_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SPO_IDLE && cmd_we && !cmd_word[VALID_BIT]) |=> (state_q == SPO_IDLE));

endmodule

// File: tb/tb_sched_pin_out.sv
`timescale 1ns/1ps
module tb_sched_pin_out;

    localparam int TW = 16;
    localparam int HW = 4;
    localparam logic [31:0] C_VALID = 32'h8000_0000;
    localparam logic [31:0] C_START = 32'h1000_0000;
    localparam logic [31:0] C_STOP  = 32'h0800_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] now_ticks = '0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_word = '0;
    logic          start_we = 1'b0;
    logic [TW-1:0] start_val = '0;
    logic          half_we = 1'b0;
    logic [HW-1:0] half_val = '0;
    logic          pin_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_run  = 1'b0;
    bit m_pin  = 1'b0;
    int m_S    = 0;
    int m_H    = 1;
    int m_sreg = 0;
    int m_hreg = 0;

    always #5 clk = ~clk;

    sched_pin_out #(.TIME_W(TW), .HALF_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .now_ticks(now_ticks),
        .cmd_we(cmd_we), .cmd_word(cmd_word),
        .start_we(start_we), .start_val(start_val),
        .half_we(half_we), .half_val(half_val),
        .pin_out(pin_out)
    );

    task automatic check_pin();
        n_tests++;
        if (pin_out !== m_pin) begin
            n_fail++;
            $display("FAIL %s t=%0d pin actual=%b expected=%b", cur_req, now_ticks, pin_out, m_pin);
        end
    endtask

    // One clock: drive inputs, model the edge, check after it, advance time.
    task automatic step(input bit cw, input logic [31:0] cv,
                        input bit sw, input int sv, input bit hw, input int hv);
        int  t;
        bit  vld, stp, sta;
        cmd_we = cw; cmd_word = cv;
        start_we = sw; start_val = TW'(sv);
        half_we = hw; half_val = HW'(hv);
        @(posedge clk);
        t   = int'(now_ticks);
        vld = cw && cv[31];
        stp = vld && cv[27];
        sta = vld && cv[28] && !cv[27];
        if (stp) m_run = 1'b0;
        else if (sta && m_sreg > t && m_hreg != 0) begin
            m_run = 1'b1; m_S = m_sreg; m_H = m_hreg; m_pin = 1'b0;
        end else if (m_run && t >= m_S) begin
            m_pin = ((((t - m_S) / m_H) + 1) % 2) == 1;
        end
        if (sw) m_sreg = sv;
        if (hw) m_hreg = hv;
        @(negedge clk);
        check_pin();
        cmd_we = 1'b0; start_we = 1'b0; half_we = 1'b0;
        now_ticks = now_ticks + 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0);
    endtask

    task automatic cmd(input logic [31:0] w);
        step(1, w, 0, 0, 0, 0);
    endtask

    task automatic set_regs(input int s, input int h);
        step(0, '0, 1, s, 1, h);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) begin
            @(negedge clk);
            check_pin();
        end
        rst_n = 1'b1;
        idle(4);

        // R2: words without valid flag, or valid without start/stop, ignored
        cur_req = "R2";
        set_regs(int'(now_ticks) + 4, 2);
        cmd(C_START);
        idle(10);
        set_regs(int'(now_ticks) + 4, 2);
        cmd(C_VALID | 32'h4000_0001);
        idle(10);

        // R3: start time equal to now, in the past, or zero interval refused
        cur_req = "R3";
        set_regs(int'(now_ticks) + 1, 3);
        cmd(C_VALID | C_START);
        idle(8);
        set_regs(int'(now_ticks) - 5, 3);
        cmd(C_VALID | C_START);
        idle(8);
        set_regs(int'(now_ticks) + 4, 0);
        cmd(C_VALID | C_START);
        idle(8);
        // boundary: one tick in the future is accepted (R4)
        cur_req = "R4";
        set_regs(int'(now_ticks) + 2, 3);
        cmd(C_VALID | C_START);
        idle(12);
        cur_req = "R7";
        cmd(C_VALID | C_STOP);
        idle(6);

        // R5: sweep every interval; R7 stop after an odd or even count
        for (int h = 1; h < 16; h++) begin
            cur_req = "R5";
            set_regs(int'(now_ticks) + 3 + (h % 3), h);
            cmd(C_VALID | C_START);
            idle(4 * h + 3 + (h % 4));
            cur_req = "R7";
            cmd(C_VALID | C_STOP);
            idle(h + 4);
            cmd(C_VALID | C_STOP);
            idle(3);
        end

        // R8: register writes during a run leave the waveform alone
        cur_req = "R8";
        set_regs(int'(now_ticks) + 3, 4);
        cmd(C_VALID | C_START);
        idle(6);
        set_regs(int'(now_ticks) + 2, 1);
        idle(20);

        // R9: restart while running with the pin high
        cur_req = "R9";
        while (pin_out !== 1'b1) idle(1);
        set_regs(int'(now_ticks) + 5, 2);
        cmd(C_VALID | C_START);
        idle(14);

        // R6: both flags act as stop, while running and while idle
        cur_req = "R6";
        cmd(C_VALID | C_START | C_STOP);
        idle(10);
        set_regs(int'(now_ticks) + 3, 2);
        cmd(C_VALID | C_START | C_STOP);
        idle(10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule